// File: doc/BRIEF.md
# Packed Single-Precision Vector Divider

This block divides a 256-bit vector of eight IEEE-754 single-precision values by a second vector of the same shape. Lane by lane it computes `src_a` over `src_b` and rounds each quotient to nearest-even. One radix-2 restoring mantissa divider serves all lanes in turn, starting at lane 0. A lane whose operands settle the result without a divide, such as a NaN, an infinity or a zero, is written in a single cycle.

The two-bit `mode` input sets how many lanes are computed and what happens to the upper 128 bits of the destination. In the merge mode the upper half takes the value presented on `dst_hi`. In the zeroing mode the upper half is cleared. In the wide mode all eight lanes are computed. The six exception conditions raised by the active lanes are ORed into one flag set for the operation.

A caller holds `start` high for one cycle while `busy` is low. The caller then waits for the single-cycle `done` pulse. `result` and `flags` keep their values until the next accepted start.

Top module: `vec_fdiv`

## Requirements
- R1: Each computed lane i gives `result[32i+31:32i]` as the correctly rounded (nearest, ties to even) single-precision quotient of the lane i of `src_a` (dividend) by the lane i of `src_b` (divisor). Subnormal operands are accepted as inputs.
- R2: Mode 2'b00 computes lanes 0 to 3. In this mode `result[255:128]` equals `dst_hi` as sampled at the accepted start and stays unchanged for the whole operation.
- R3: Mode 2'b01 computes lanes 0 to 3 and gives `result[255:128]` = 0.
- R4: Modes 2'b10 and 2'b11 compute all eight lanes.
- R5: The following cases give 0x7FC00000 and set the invalid flag: a signalling NaN operand (exponent all ones, fraction nonzero, fraction bit 22 clear), 0/0, and infinity/infinity. Otherwise a quiet NaN dividend is returned unchanged. Failing that, a quiet NaN divisor is returned unchanged.
- R6: Every non-NaN result has the XOR of the operand signs as its sign. A finite nonzero value over zero gives infinity and sets the divide-by-zero flag. Infinity over a finite value gives infinity. Zero over a nonzero value gives zero. A finite value over infinity gives zero.
- R7: A rounded magnitude beyond the largest finite value gives infinity and sets the overflow and inexact flags.
- R8: A quotient whose unrounded exponent lies below the normal range is rounded to a subnormal or to zero (ties to even). It sets the underflow flag only if it is also inexact. Any rounded lane that differs from the exact quotient sets the inexact flag.
- R9: A lane with a subnormal operand and no NaN operand sets the denormal flag.
- R10: `flags` bit order is [0] invalid, [1] denormal, [2] divide-by-zero, [3] overflow, [4] underflow, [5] inexact. `flags` is cleared at each accepted start and then collects flags only from the lanes computed in that operation.
- R11: `start` is accepted only while `busy` is low. A start during `busy` has no effect. `done` is high for exactly one cycle, the cycle after the last computed lane is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (ignored while busy) |
| mode | input | 2 | 00 merge upper half, 01 zero upper half, 1x full width |
| src_a | input | 256 | Dividend vector, eight 32-bit lanes |
| src_b | input | 256 | Divisor vector, eight 32-bit lanes |
| dst_hi | input | 128 | Previous upper destination half, used in merge mode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 256 | Quotient vector |
| flags | output | 6 | Exception flags of the last operation |

## Verification
Any fault inside the divider appears at the ports on the same `done` pulse that ends the operation, and nowhere else.

- A quotient bit shifted in wrongly, or a remainder left stale between lanes, shows as wrong low mantissa bits or a wrong rounding direction. It affects only the lane being divided.
- A slip in the lane index places a quotient in the neighbouring lane.
- A slip in the last-lane decode shows as an upper half that was computed when it should have been kept or cleared.
- A flag wrongly taken from an inactive lane, or not cleared at start, shows as extra bits in `flags`.

The sweep therefore compares every lane and the upper half after every operation, across all four modes.

// File: rtl/vec_fdiv.sv
module vec_fdiv #(
  parameter int LANES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            mode,
  input  logic [LANES*32-1:0]   src_a,
  input  logic [LANES*32-1:0]   src_b,
  input  logic [LANES*16-1:0]   dst_hi,
  output logic                  busy,
  output logic                  done,
  output logic [LANES*32-1:0]   result,
  output logic [5:0]            flags
);
  localparam int VW   = LANES * 32;
  localparam int HALF = VW / 2;
  localparam int LIX  = $clog2(LANES);
  localparam int QW   = 26;
  localparam int F_INV = 0, F_DN = 1, F_DZ = 2, F_OVF = 3, F_UNF = 4, F_INX = 5;
  localparam logic [31:0] QNAN = 32'h7FC0_0000;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_DIV, S_RND, S_DONE} st_t;
  st_t st;

  logic [VW-1:0]  opa, opb;
  logic [1:0]     md;
  logic [LIX-1:0] lane;
  logic [QW-1:0]  r, q;
  logic [23:0]    dv;
  logic signed [10:0] ex;
  logic           sg;
  logic [4:0]     cnt;

  function automatic logic [4:0] lzc(input logic [23:0] m);
    lzc = 5'd0;
    for (int i = 0; i < 24; i++)
      if (m[i]) lzc = 5'(23 - i);
  endfunction

  logic [31:0] la, lb;
  assign la = opa[lane*32 +: 32];
  assign lb = opb[lane*32 +: 32];

  logic [7:0]  a_e, b_e;
  logic [22:0] a_f, b_f;
  assign a_e = la[30:23];
  assign b_e = lb[30:23];
  assign a_f = la[22:0];
  assign b_f = lb[22:0];

  logic a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_zero, b_zero, a_sub, b_sub, rs;
  assign a_nan  = (&a_e) && (|a_f);
  assign b_nan  = (&b_e) && (|b_f);
  assign a_snan = a_nan && !a_f[22];
  assign b_snan = b_nan && !b_f[22];
  assign a_inf  = (&a_e) && !(|a_f);
  assign b_inf  = (&b_e) && !(|b_f);
  assign a_zero = (a_e == 8'd0) && !(|a_f);
  assign b_zero = (b_e == 8'd0) && !(|b_f);
  assign a_sub  = (a_e == 8'd0) && (|a_f);
  assign b_sub  = (b_e == 8'd0) && (|b_f);
  assign rs     = la[31] ^ lb[31];

  logic [23:0] a_raw, b_raw, a_m, b_m;
  logic [4:0]  a_lz, b_lz;
  logic signed [10:0] a_x, b_x;
  assign a_raw = {|a_e, a_f};
  assign b_raw = {|b_e, b_f};
  assign a_lz  = lzc(a_raw);
  assign b_lz  = lzc(b_raw);
  assign a_m   = a_raw << a_lz;
  assign b_m   = b_raw << b_lz;
  assign a_x   = (a_e == 8'd0 ? 11'sd1 : $signed({3'b000, a_e})) - $signed({6'b0, a_lz});
  assign b_x   = (b_e == 8'd0 ? 11'sd1 : $signed({3'b000, b_e})) - $signed({6'b0, b_lz});

  logic        sp_hit;
  logic [31:0] sp_val;
  logic [5:0]  sp_fl;
  always_comb begin
    sp_hit = 1'b1;
    sp_val = '0;
    sp_fl  = '0;
    if (a_snan || b_snan || (a_zero && b_zero) || (a_inf && b_inf)) begin
      sp_val = QNAN;
      sp_fl[F_INV] = 1'b1;
    end else if (a_nan) sp_val = la;
    else if (b_nan) sp_val = lb;
    else if (a_inf) sp_val = {rs, 8'hFF, 23'b0};
    else if (b_zero) begin
      sp_val = {rs, 8'hFF, 23'b0};
      sp_fl[F_DZ] = 1'b1;
    end else if (a_zero || b_inf) sp_val = {rs, 31'b0};
    else sp_hit = 1'b0;
    if (!(a_nan || b_nan) && (a_sub || b_sub)) sp_fl[F_DN] = 1'b1;
  end

  logic          a_ge;
  assign a_ge = a_m >= b_m;

  logic          d_ge;
  logic [QW-1:0] d_rem;
  assign d_ge  = r >= {2'b00, dv};
  assign d_rem = d_ge ? r - {2'b00, dv} : r;

  logic signed [10:0] dsh, ef;
  logic [5:0]   sh;
  logic [QW-1:0] qs;
  logic [23:0]  m24;
  logic [24:0]  mr;
  logic         tiny, lost, g, stk, rup, inx, ovf;
  logic [31:0]  rn_val;
  logic [5:0]   rn_fl;
  always_comb begin
    tiny = ex < 11'sd1;
    dsh  = 11'sd1 - ex;
    sh   = !tiny ? 6'd0 : (dsh > 11'sd31 ? 6'd31 : dsh[5:0]);
    qs   = q >> sh;
    lost = ((qs << sh) != q) || (r != '0);
    m24  = qs[25:2];
    g    = qs[1];
    stk  = qs[0] | lost;
    rup  = g & (stk | m24[0]);
    mr   = {1'b0, m24} + {24'b0, rup};
    inx  = g | stk;
    ef   = tiny ? $signed({10'b0, mr[23]}) : ex + $signed({10'b0, mr[24]});
    ovf  = ef >= 11'sd255;
    rn_val = ovf ? {sg, 8'hFF, 23'b0} : {sg, ef[7:0], mr[22:0]};
    rn_fl  = '0;
    rn_fl[F_OVF] = ovf;
    rn_fl[F_UNF] = tiny & inx;
    rn_fl[F_INX] = inx | ovf;
  end

  logic is_last;
  assign is_last = lane == (md[1] ? LIX'(LANES - 1) : LIX'(LANES / 2 - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      opa <= '0;
      opb <= '0;
      md <= '0;
      lane <= '0;
      result <= '0;
      flags <= '0;
      r <= '0;
      q <= '0;
      dv <= '0;
      ex <= '0;
      sg <= 1'b0;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (start) begin
            opa <= src_a;
            opb <= src_b;
            md <= mode;
            lane <= '0;
            flags <= '0;
            result <= (mode == 2'b00) ? {dst_hi, {HALF{1'b0}}} : '0;
            st <= S_LOAD;
          end else st <= S_IDLE;
        end
        S_LOAD: begin
          flags <= flags | sp_fl;
          if (sp_hit) begin
            result[lane*32 +: 32] <= sp_val;
            if (is_last) st <= S_DONE;
            else begin
              lane <= lane + 1'b1;
              st <= S_LOAD;
            end
          end else begin
            r  <= a_ge ? {2'b00, a_m} : {1'b0, a_m, 1'b0};
            dv <= b_m;
            ex <= a_x - b_x + 11'sd127 - (a_ge ? 11'sd0 : 11'sd1);
            sg <= rs;
            q  <= '0;
            cnt <= '0;
            st <= S_DIV;
          end
        end
        S_DIV: begin
          r   <= {d_rem[QW-2:0], 1'b0};
          q   <= {q[QW-2:0], d_ge};
          cnt <= cnt + 5'd1;
          if (cnt == 5'(QW - 1)) st <= S_RND;
        end
        S_RND: begin
          result[lane*32 +: 32] <= rn_val;
          flags <= flags | rn_fl;
          if (is_last) st <= S_DONE;
          else begin
            lane <= lane + 1'b1;
            st <= S_LOAD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = (st == S_LOAD) || (st == S_DIV) || (st == S_RND);
  assign done = st == S_DONE;

  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DIV) |-> (r < {1'b0, dv, 1'b0})) else $error("remainder out of range"); // R1
  AST_QUOT_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RND) |-> q[QW-1]) else $error("quotient not normalized"); // R1
  AST_MERGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && md == 2'b00) |=> $stable(result[VW-1:HALF])) else $error("upper half moved"); // R2
  AST_ZERO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (done && md == 2'b01) |-> (result[VW-1:HALF] == '0)) else $error("upper half not zero"); // R3
  AST_FLAGS_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (flags == '0)) else $error("flags not cleared"); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R11
endmodule

// File: tb/sim_vec_fdiv.sv
`timescale 1ns/1ps
module sim_vec_fdiv;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'b10;
  logic [255:0] src_a = '0, src_b = '0;
  logic [127:0] dst_hi = '0;
  logic busy, done;
  logic [255:0] result;
  logic [5:0] flags;

  int total = 0, bad = 0;
  logic [255:0] res;
  logic [5:0] flg;

  always #10 clk = ~clk;

  vec_fdiv #(.LANES(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .src_a(src_a), .src_b(src_b), .dst_hi(dst_hi),
    .busy(busy), .done(done), .result(result), .flags(flags));

  task automatic chk(input string rq, input string what, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] f2d(input logic [31:0] f);
    logic [23:0] m;
    int x;
    if (f[30:23] == 8'd0) begin
      m = {1'b0, f[22:0]};
      x = -126;
      while (!m[23]) begin
        m = m << 1;
        x--;
      end
    end else begin
      m = {1'b1, f[22:0]};
      x = int'(f[30:23]) - 127;
    end
    return {f[31], 11'(x + 1023), m[22:0], 29'b0};
  endfunction

  function automatic logic [31:0] d2f(input logic [63:0] d);
    logic s;
    int e, sh;
    logic [63:0] m, keep, rem, half;
    s = d[63];
    e = int'(d[62:52]) - 896;
    m = {11'b0, 1'b1, d[51:0]};
    sh = (e >= 1) ? 29 : 30 - e;
    if (sh > 62) sh = 62;
    keep = m >> sh;
    rem  = m & ((64'd1 << sh) - 64'd1);
    half = 64'd1 << (sh - 1);
    if (rem > half || (rem == half && keep[0])) keep = keep + 64'd1;
    if (e >= 1) begin
      if (keep[24]) begin
        keep = keep >> 1;
        e = e + 1;
      end
      if (e >= 255) return {s, 8'hFF, 23'b0};
      return {s, 8'(e), keep[22:0]};
    end
    return {s, 7'b0, keep[23], keep[22:0]};
  endfunction

  function automatic logic isnan(input logic [31:0] v);
    return (&v[30:23]) && (|v[22:0]);
  endfunction
  function automatic logic issnan(input logic [31:0] v);
    return isnan(v) && !v[22];
  endfunction
  function automatic logic isinf(input logic [31:0] v);
    return (&v[30:23]) && !(|v[22:0]);
  endfunction
  function automatic logic iszero(input logic [31:0] v);
    return v[30:0] == 31'd0;
  endfunction
  function automatic logic issub(input logic [31:0] v);
    return v[30:23] == 8'd0 && (|v[22:0]);
  endfunction

  function automatic logic [31:0] ref_div(input logic [31:0] a, input logic [31:0] b);
    logic s;
    s = a[31] ^ b[31];
    if (issnan(a) || issnan(b) || (iszero(a) && iszero(b)) || (isinf(a) && isinf(b))) return 32'h7FC00000;
    if (isnan(a)) return a;
    if (isnan(b)) return b;
    if (isinf(a) || iszero(b)) return {s, 8'hFF, 23'b0};
    if (iszero(a) || isinf(b)) return {s, 31'b0};
    return d2f($realtobits($bitstoreal(f2d(a)) / $bitstoreal(f2d(b))));
  endfunction

  function automatic logic [31:0] rnd_f();
    logic [31:0] v;
    v = $urandom;
    case ($urandom % 4)
      1: v[30:23] = 8'(117 + $urandom % 21);
      2: v[30:23] = 8'($urandom % 12);
      3: v[30:23] = 8'(240 + $urandom % 15);
      default: ;
    endcase
    return v;
  endfunction

  task automatic run(input logic [1:0] m, input logic [255:0] a, input logic [255:0] b, input logic [127:0] d);
    @(negedge clk);
    mode = m; src_a = a; src_b = b; dst_hi = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    res = result;
    flg = flags;
  endtask

  task automatic check_vec(input logic [1:0] m, input logic [255:0] a, input logic [255:0] b, input logic [127:0] d);
    int n;
    logic [2:0] ef;
    n = m[1] ? 8 : 4;
    ef = '0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] x, y;
      x = a[i*32 +: 32];
      y = b[i*32 +: 32];
      chk(m[1] && i >= 4 ? "R4" : "R1", $sformatf("lane%0d %h/%h", i, x, y), 256'(res[i*32 +: 32]), 256'(ref_div(x, y)));
      if (issnan(x) || issnan(y) || (iszero(x) && iszero(y)) || (isinf(x) && isinf(y))) ef[0] = 1'b1;
      if (!isnan(x) && !isnan(y)) begin
        if (issub(x) || issub(y)) ef[1] = 1'b1;
        if (!isinf(x) && iszero(y) && !iszero(x)) ef[2] = 1'b1;
      end
    end
    if (m == 2'b00) chk("R2", "merged upper half", 256'(res[255:128]), 256'(d));
    if (m == 2'b01) chk("R3", "zeroed upper half", 256'(res[255:128]), 256'(0));
    chk("R10", "active-lane flags[2:0]", 256'(flg[2:0]), 256'(ef));
  endtask

  task automatic check_lanes(input string rq, input logic [255:0] exp);
    for (int i = 0; i < 8; i++)
      chk(rq, $sformatf("lane%0d", i), 256'(res[i*32 +: 32]), 256'(exp[i*32 +: 32]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [255:0] A, B, E, A2;
    logic [127:0] D;
    repeat (3) @(negedge clk);
    chk("R11", "reset busy", 256'(busy), 256'(0));
    chk("R11", "reset done", 256'(done), 256'(0));
    chk("R10", "reset flags", 256'(flags), 256'(0));
    chk("R1", "reset result", result, 256'(0));
    rst_n = 1'b1;

    // R5 R6: special operands
    A = {32'hFF800000, 32'h40400000, 32'hBF800000, 32'h3F800000, 32'h7FC01234, 32'h7F800001, 32'h7F800000, 32'h00000000};
    B = {32'h40000000, 32'h7F800000, 32'h00000000, 32'hFFC00055, 32'h3F800000, 32'h3F800000, 32'hFF800000, 32'h00000000};
    E = {32'hFF800000, 32'h00000000, 32'hFF800000, 32'hFFC00055, 32'h7FC01234, 32'h7FC00000, 32'h7FC00000, 32'h7FC00000};
    run(2'b10, A, B, '0);
    check_lanes("R5", E);
    chk("R6", "special flags", 256'(flg), 256'(6'b000101));

    // R7: overflow of both signs
    A = {{6{32'h3F800000}}, 32'hFF7FFFFF, 32'h7F7FFFFF};
    B = {{6{32'h3F800000}}, 32'h3F000000, 32'h3F000000};
    E = {{6{32'h3F800000}}, 32'hFF800000, 32'h7F800000};
    run(2'b11, A, B, '0);
    check_lanes("R7", E);
    chk("R7", "overflow flags", 256'(flg), 256'(6'b101000));

    // R8 R9: subnormal results, ties to even, tiny exact
    A = {32'h40C00000, 32'h3F800000, 32'h80000003, 32'h00000005, 32'h00000001, 32'h00000003, 32'h00800000, 32'h00800000};
    B = {32'h40000000, 32'h3F800000, 32'h40000000, 32'h40000000, 32'h40000000, 32'h40000000, 32'h40400000, 32'h40000000};
    E = {32'h40400000, 32'h3F800000, 32'h80000002, 32'h00000002, 32'h00000000, 32'h00000002, 32'h002AAAAB, 32'h00400000};
    run(2'b10, A, B, '0);
    check_lanes("R8", E);
    chk("R8", "underflow flags", 256'(flg), 256'(6'b110010));

    // R8: exact tiny quotient raises no underflow
    A = {{7{32'h3F800000}}, 32'h00800000};
    B = {{7{32'h3F800000}}, 32'h40000000};
    run(2'b10, A, B, '0);
    chk("R8", "exact tiny lane0", 256'(res[31:0]), 256'(32'h00400000));
    chk("R8", "exact tiny flags", 256'(flg), 256'(6'b000000));

    // R9: subnormal operand, exact result
    A = {{7{32'h3F800000}}, 32'h00000001};
    B = {{7{32'h3F800000}}, 32'h3F000000};
    run(2'b10, A, B, '0);
    chk("R9", "denormal lane0", 256'(res[31:0]), 256'(32'h00000002));
    chk("R9", "denormal flags", 256'(flg), 256'(6'b000010));

    // R1: rounding of normal quotients
    A = {32'h7F7FFFFF, 32'h3F800000, 32'h40C00000, 32'hBF800000, 32'h3F800000, 32'h3F800000, 32'h40000000, 32'h3F800000};
    B = {32'h7F7FFFFF, 32'h3F800000, 32'h40000000, 32'h40400000, 32'h41200000, 32'h40E00000, 32'h40400000, 32'h40400000};
    E = {32'h3F800000, 32'h3F800000, 32'h40400000, 32'hBEAAAAAB, 32'h3DCCCCCD, 32'h3E124925, 32'h3F2AAAAB, 32'h3EAAAAAB};
    run(2'b10, A, B, '0);
    check_lanes("R1", E);
    chk("R8", "inexact only flags", 256'(flg), 256'(6'b100000));

    // R10 R2: inactive upper lanes hold 0/0 and subnormals, no flags
    A = {{4{32'h00000000}}, {4{32'h3F800000}}};
    B = {{4{32'h00000000}}, {4{32'h3F800000}}};
    D = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    run(2'b00, A, B, D);
    chk("R2", "merge upper", 256'(res[255:128]), 256'(D));
    chk("R1", "merge lower", 256'(res[127:0]), 256'({4{32'h3F800000}}));
    chk("R10", "inactive lanes flags", 256'(flg), 256'(0));
    A = {{4{32'h00000001}}, {4{32'h3F800000}}};
    run(2'b01, A, B, D);
    chk("R3", "zero upper", 256'(res[255:128]), 256'(0));
    chk("R10", "inactive denormal flags", 256'(flg), 256'(0));

    // R11: start while busy has no effect; done lasts one cycle
    A = {8{32'h40400000}};
    B = {8{32'h3F800000}};
    A2 = {8{32'h00000000}};
    @(negedge clk);
    mode = 2'b10; src_a = A; src_b = B; dst_hi = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11", "busy mid-op", 256'(busy), 256'(1));
    mode = 2'b00; src_a = A2; src_b = A2; dst_hi = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    res = result;
    flg = flags;
    check_lanes("R11", A);
    chk("R11", "flags after ignored start", 256'(flg), 256'(0));
    @(negedge clk);
    chk("R11", "done single cycle", 256'(done), 256'(0));
    chk("R11", "result held", result, A);

    // R1 R2 R3 R4 R10: random sweep over every mode
    for (int t = 0; t < 300; t++) begin
      logic [1:0] m;
      m = 2'($urandom % 4);
      for (int i = 0; i < 8; i++) begin
        A[i*32 +: 32] = rnd_f();
        B[i*32 +: 32] = rnd_f();
      end
      D = {$urandom, $urandom, $urandom, $urandom};
      run(m, A, B, D);
      check_vec(m, A, B, D);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule